// File: doc/BRIEF.md
# Command Stream Front-End Processor

The block runs a chain of 64-bit command packets that a host CPU has placed in memory. The host writes a start address and then an end address into two registers. The second write starts execution. From then on the block fetches one packet at a time over a memory request port, decodes it and carries it out. Each packet is one of five things: a skip, a jump, a write on an internal register bus, a store of an immediate label value to memory, or a wait that polls a memory word until a comparison holds. After the packet at the end address has finished, the block returns to idle.

Subroutine calls need no return stack. The caller jumps into the callee, and the callee ends with a jump back to the packet that follows the caller's jump. A skip packet names the address of the next packet to run, so the words between the two stay in the stream as inline data. Label polling reads memory again on every try and leaves a fixed quiet gap between tries. The block has no cache, so making CPU data visible in memory is left to the host.

Top module: `cmd_stream_fe`

## Requirements
- R1: After reset `idle_o` is 1, and `mem_req_o` and `reg_we_o` are 0.
- R2: A write with `host_sel_i`=0 while idle loads the start address. A write with `host_sel_i`=1 while idle loads the end address, and in the next cycle a read request to the start address is raised.
- R3: The opcode is packet bits [63:60]: 0 skip, 1 jump, 2 register write, 3 label store, 4 label wait. A packet address field sits at bits [32+ADDR_W-4:32] and holds the byte address divided by 8.
- R4: A skip packet makes the next fetch go to its address field times 8. Packets in between are not executed.
- R5: A jump packet makes the next fetch go to its address field times 8. Paired jumps give call and return.
- R6: A register-write packet raises `reg_we_o` for exactly one cycle. `reg_addr_o` comes from bits [59:60-RA_W] and `reg_wdata_o` from bits [31:0].
- R7: A label-store packet issues one memory write of bits [31:0] to its address field times 8.
- R8: A label-wait packet reads the word at its address field times 8 and compares the low 32 bits, as value against reference, with the reference in bits [31:0]. The compare mode is bits [59:56]: 0 equal, 1 not equal, 2 unsigned greater-or-equal, 3 unsigned less-than, and any other code acts as equal. The block moves on only once the comparison holds.
- R9: Between a failed poll response and the next poll request, `mem_req_o` stays low for at least max(POLL_GAP,16) cycles.
- R10: Any opcode not listed in R3 acts as a skip to the next sequential packet (address + 8).
- R11: Once the packet at the end address completes, no further fetch is made and `idle_o` returns to 1.
- R12: A request that is not granted keeps `mem_req_o`, `mem_we_o` and `mem_addr_o` unchanged until `mem_gnt_i` is high. Exactly one read is outstanding, and its response arrives on `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_sel_i | input | 1 | 0 selects the start address, 1 selects the end address (the end write starts execution) |
| host_wdata_i | input | ADDR_W | Host write data (byte address) |
| mem_req_o | output | 1 | Memory request valid |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | 1 for a write request, 0 for a read |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | 32 | Write data for label stores |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read response data |
| reg_we_o | output | 1 | Internal register write strobe |
| reg_addr_o | output | RA_W | Internal register address |
| reg_wdata_o | output | 32 | Internal register write data |
| idle_o | output | 1 | High when no stream is running |

## Verification
The first fetch request is due in the cycle right after the edge that takes the end-address write. The bench samples it at the following falling edge. A register write or label store shows up one cycle after the edge that delivers the packet's read response, and the grant stalls that the bench's memory model inserts push that edge back. For that reason the bench logs every request handshake and register strobe at the clock edge where it happens. It then compares the ordered logs (fetch addresses, register writes, label stores) against the expected sequence once `idle_o` comes back. It does not predict absolute cycle numbers. The poll gap is measured by counting the edges with the request low between a label response and the next label request.

// File: rtl/cmd_stream_pkg.sv
package cmd_stream_pkg;
  localparam int PKT_W = 64;
  localparam logic [3:0] OP_SKIP = 4'h0;
  localparam logic [3:0] OP_JUMP = 4'h1;
  localparam logic [3:0] OP_WREG = 4'h2;
  localparam logic [3:0] OP_WLBL = 4'h3;
  localparam logic [3:0] OP_WAIT = 4'h4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FRSP, S_EXEC, S_LWR, S_PREQ, S_PRSP, S_GAP
  } fe_state_e;
endpackage

// File: rtl/cmd_stream_decode.sv
module cmd_stream_decode
  import cmd_stream_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int RA_W   = 8
) (
  input  logic [PKT_W-1:0]  pkt_i,
  output logic [3:0]        op_o,
  output logic [3:0]        mode_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [RA_W-1:0]   ra_o,
  output logic [31:0]       lo_o
);
  localparam int AFW = ADDR_W - 3;

  logic unused_bits;
  assign unused_bits = ^pkt_i;

  assign op_o   = pkt_i[63:60];
  assign mode_o = pkt_i[59:56];
  assign tgt_o  = {pkt_i[32 +: AFW], 3'b000};
  assign ra_o   = pkt_i[59 -: RA_W];
  assign lo_o   = pkt_i[31:0];
endmodule

// File: rtl/cmd_stream_cmp.sv
module cmd_stream_cmp (
  input  logic [3:0]  mode_i,
  input  logic [31:0] val_i,
  input  logic [31:0] ref_i,
  output logic        pass_o
);
  always_comb begin
    unique case (mode_i)
      4'd1:    pass_o = (val_i != ref_i);
      4'd2:    pass_o = (val_i >= ref_i);
      4'd3:    pass_o = (val_i <  ref_i);
      default: pass_o = (val_i == ref_i);
    endcase
  end
endmodule

// File: rtl/cmd_stream_gap.sv
module cmd_stream_gap #(
  parameter int GAP = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(GAP);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cmd_stream_fe.sv
module cmd_stream_fe
  import cmd_stream_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RA_W     = 8,
  parameter int POLL_GAP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [ADDR_W-1:0] host_wdata_i,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [PKT_W-1:0]  mem_rdata_i,
  output logic              reg_we_o,
  output logic [RA_W-1:0]   reg_addr_o,
  output logic [31:0]       reg_wdata_o,
  output logic              idle_o
);
  localparam int GAP_EFF = (POLL_GAP < 16) ? 16 : POLL_GAP;

  fe_state_e          st_q, st_d;
  logic [ADDR_W-1:0]  pc_q, pc_d, first_q, last_q;
  logic [PKT_W-1:0]   pkt_q;
  logic [3:0]         op, mode;
  logic [ADDR_W-1:0]  tgt, seq_pc, adv_pc;
  logic [RA_W-1:0]    ra;
  logic [31:0]        lo;
  logic               pass, adv, gap_start, gap_done;

  cmd_stream_decode #(.ADDR_W(ADDR_W), .RA_W(RA_W)) u_dec (
    .pkt_i(pkt_q), .op_o(op), .mode_o(mode), .tgt_o(tgt), .ra_o(ra), .lo_o(lo)
  );

  cmd_stream_cmp u_cmp (
    .mode_i(mode), .val_i(mem_rdata_i[31:0]), .ref_i(lo), .pass_o(pass)
  );

  cmd_stream_gap #(.GAP(GAP_EFF)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(gap_start), .expired_o(gap_done)
  );

  assign seq_pc = pc_q + ADDR_W'(8);

  always_comb begin
    st_d      = st_q;
    pc_d      = pc_q;
    adv       = 1'b0;
    adv_pc    = seq_pc;
    gap_start = 1'b0;
    unique case (st_q)
      S_IDLE:  if (host_we_i && host_sel_i) begin
                 st_d = S_FETCH;
                 pc_d = first_q;
               end
      S_FETCH: if (mem_gnt_i) st_d = S_FRSP;
      S_FRSP:  if (mem_rvalid_i) st_d = S_EXEC;
      S_EXEC:  begin
        if (op == OP_SKIP || op == OP_JUMP) begin
          adv    = 1'b1;
          adv_pc = tgt;
        end else if (op == OP_WLBL) st_d = S_LWR;
        else if (op == OP_WAIT)     st_d = S_PREQ;
        else                        adv  = 1'b1; // reg write and undefined codes
      end
      S_LWR:   if (mem_gnt_i) adv = 1'b1;
      S_PREQ:  if (mem_gnt_i) st_d = S_PRSP;
      S_PRSP:  if (mem_rvalid_i) begin
                 if (pass) adv = 1'b1;
                 else begin
                   st_d      = S_GAP;
                   gap_start = 1'b1;
                 end
               end
      S_GAP:   if (gap_done) st_d = S_PREQ;
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      if (pc_q == last_q) st_d = S_IDLE;
      else begin
        st_d = S_FETCH;
        pc_d = adv_pc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      pc_q    <= '0;
      first_q <= '0;
      last_q  <= '0;
      pkt_q   <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
      if (st_q == S_IDLE && host_we_i && !host_sel_i) first_q <= host_wdata_i;
      if (st_q == S_IDLE && host_we_i &&  host_sel_i) last_q  <= host_wdata_i;
      if (st_q == S_FRSP && mem_rvalid_i)             pkt_q   <= mem_rdata_i;
    end
  end

  assign mem_req_o   = (st_q == S_FETCH) || (st_q == S_LWR) || (st_q == S_PREQ);
  assign mem_we_o    = (st_q == S_LWR);
  assign mem_addr_o  = (st_q == S_FETCH) ? pc_q : tgt;
  assign mem_wdata_o = lo;
  assign reg_we_o    = (st_q == S_EXEC) && (op == OP_WREG);
  assign reg_addr_o  = ra;
  assign reg_wdata_o = lo;
  assign idle_o      = (st_q == S_IDLE);

  // checker-only: states spent quiet since the last failed poll
  logic [15:0] gap_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   gap_seen_q <= '0;
    else if (st_q == S_PRSP)                       gap_seen_q <= '0;
    else if (st_q == S_GAP && gap_seen_q != '1)    gap_seen_q <= gap_seen_q + 1'b1;
  end

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R12
  rsp_expected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> (st_q == S_FRSP || st_q == S_PRSP));

  // R2
  start_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && host_we_i && host_sel_i) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(first_q)));

  // R6
  reg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R9
  poll_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PREQ && $past(st_q) == S_GAP) |-> (32'(gap_seen_q) >= GAP_EFF));

  // R11
  stop_at_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> ($past(pc_q) == last_q));
endmodule

// File: tb/sim_cmd_stream_fe.sv
`timescale 1ns/1ps
module sim_cmd_stream_fe;
  localparam int ADDR_W = 16;
  localparam int RA_W   = 8;
  localparam int POLL_GAP = 16;
  localparam logic [15:0] LBL = 16'h0480;
  localparam logic [15:0] WPK = 16'h0400;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic host_we_i = 1'b0, host_sel_i = 1'b0;
  logic [ADDR_W-1:0] host_wdata_i = '0;
  logic mem_req_o, mem_gnt_i, mem_we_o, mem_rvalid_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [63:0] mem_rdata_i;
  logic reg_we_o, idle_o;
  logic [RA_W-1:0] reg_addr_o;
  logic [31:0] reg_wdata_o;

  always #10 clk_i = ~clk_i;

  cmd_stream_fe #(.ADDR_W(ADDR_W), .RA_W(RA_W), .POLL_GAP(POLL_GAP)) u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] mem [0:255];
  logic stall_t = 1'b0, gnt_all = 1'b0, rvalid_q = 1'b0;
  logic [63:0] rdata_q = '0;
  logic [15:0] rd_addr_q = '0;
  logic [15:0] rd_log [0:31];
  logic [39:0] reg_log [0:7];
  logic [15:0] wr_log [0:7];
  int n_rd = 0, n_reg = 0, n_wr = 0, lbl_reads = 0;
  int quiet = 0, min_quiet = 1000;
  bit armed = 0;

  assign mem_gnt_i    = gnt_all | stall_t;
  assign mem_rvalid_i = rvalid_q;
  assign mem_rdata_i  = rdata_q;

  always @(posedge clk_i) begin
    stall_t  <= ~stall_t;
    rvalid_q <= 1'b0;
    if (mem_rvalid_i && rd_addr_q == LBL) begin
      armed = 1; quiet = 0;
    end else if (armed) begin
      if (mem_req_o) begin
        if (mem_addr_o == LBL && quiet < min_quiet) min_quiet = quiet;
        armed = 0;
      end else quiet++;
    end
    if (reg_we_o && n_reg < 8) begin reg_log[n_reg] = {reg_addr_o, reg_wdata_o}; n_reg++; end
    if (mem_req_o && mem_gnt_i) begin
      if (mem_we_o) begin
        mem[mem_addr_o[10:3]][31:0] = mem_wdata_o;
        if (n_wr < 8) wr_log[n_wr] = mem_addr_o;
        n_wr++;
      end else begin
        rvalid_q  <= 1'b1;
        rdata_q   <= mem[mem_addr_o[10:3]];
        rd_addr_q <= mem_addr_o;
        if (mem_addr_o == LBL) lbl_reads++;
        if (n_rd < 32) rd_log[n_rd] = mem_addr_o;
        n_rd++;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R11 watchdog: act=busy exp=idle");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pk_addr(input logic [3:0] op, input logic [3:0] fl,
                                          input logic [15:0] a, input logic [31:0] lo);
    return {op, fl, 11'd0, a[15:3], lo};
  endfunction

  function automatic logic [63:0] pk_wreg(input logic [7:0] ra, input logic [31:0] d);
    return {4'h2, ra, 20'd0, d};
  endfunction

  function automatic bit cmp_model(input logic [3:0] m, input logic [31:0] v, input logic [31:0] r);
    case (m)
      4'd1: return v != r;
      4'd2: return v >= r;
      4'd3: return v < r;
      default: return v == r;
    endcase
  endfunction

  function automatic logic [31:0] fix_val(input logic [3:0] m, input logic [31:0] r);
    case (m)
      4'd1: return r + 1;
      4'd3: return r - 1;
      default: return r;
    endcase
  endfunction

  task automatic host_wr(input bit sel, input logic [15:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_sel_i = sel; host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic clear_logs();
    n_rd = 0; n_reg = 0; n_wr = 0; lbl_reads = 0;
  endtask

  task automatic run_idle(input int limit, output bit reached);
    reached = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i);
      if (idle_o) begin reached = 1; break; end
    end
  endtask

  // {mode, reference, label value}
  localparam logic [67:0] CMP_TBL [11] = '{
    {4'd0, 32'd5,  32'd5},  {4'd0, 32'd5,  32'd6},
    {4'd1, 32'd5,  32'd6},  {4'd1, 32'd7,  32'd7},
    {4'd2, 32'd10, 32'd10}, {4'd2, 32'd10, 32'd9},
    {4'd2, 32'd1,  32'h8000_0000},
    {4'd3, 32'd10, 32'd9},  {4'd3, 32'd10, 32'd10},
    {4'd7, 32'd3,  32'd3},  {4'd7, 32'd3,  32'd4}
  };

  localparam logic [15:0] EXP_FETCH [8] = '{16'h100, 16'h118, 16'h120, 16'h200,
                                            16'h208, 16'h210, 16'h218, 16'h128};

  initial begin
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // R1: reset state
    #5;
    chk(idle_o == 1'b1 && mem_req_o == 1'b0 && reg_we_o == 1'b0, "R1 reset", {idle_o, mem_req_o, reg_we_o}, 3'b100);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(idle_o == 1'b1 && mem_req_o == 1'b0, "R1 after release", {idle_o, mem_req_o}, 2'b10);

    // label wait compare table (R8, R9)
    gnt_all = 1'b1;
    foreach (CMP_TBL[k]) begin
      logic [3:0] m; logic [31:0] r, v; bit exp_pass;
      {m, r, v} = CMP_TBL[k];
      exp_pass = cmp_model(m, v, r);
      mem[WPK[10:3]] = pk_addr(4'h4, m, LBL, r);
      mem[LBL[10:3]] = {32'hFFFF_0000, v};
      clear_logs();
      host_wr(1'b0, WPK);
      host_wr(1'b1, WPK);
      if (exp_pass) begin
        run_idle(300, ok);
        chk(ok, "R8 compare passes at once", ok, 1);
        chk(lbl_reads == 1, "R8 single poll read", lbl_reads, 1);
      end else begin
        run_idle(300, ok);
        chk(!ok, "R8 compare holds stream", ok, 0);
        chk(lbl_reads >= 2, "R8 repeated polls", lbl_reads, 2);
        mem[LBL[10:3]][31:0] = fix_val(m, r);
        run_idle(100, ok);
        chk(ok, "R8 resumes after label update", ok, 1);
      end
    end
    chk(min_quiet >= POLL_GAP, "R9 poll gap", min_quiet, POLL_GAP);

    // chained stream with stalls: skip, jump-based call/return, reg/label writes, undefined op
    gnt_all = 1'b0;
    mem[8'h20] = pk_addr(4'h0, 4'h0, 16'h118, 32'h0);        // 0x100 skip -> 0x118
    mem[8'h21] = pk_wreg(8'hEE, 32'h1);                      // 0x108 inline data
    mem[8'h22] = pk_wreg(8'hEE, 32'h2);                      // 0x110 inline data
    mem[8'h23] = pk_wreg(8'h5A, 32'hDEAD_BEEF);              // 0x118
    mem[8'h24] = pk_addr(4'h1, 4'h0, 16'h200, 32'h0);        // 0x120 call
    mem[8'h25] = pk_wreg(8'h22, 32'd9);                      // 0x128 last
    mem[8'h40] = pk_addr(4'h3, 4'h0, 16'h300, 32'h1234);     // 0x200 label store
    mem[8'h41] = {4'hF, 60'h0_1234_5678_9ABC};               // 0x208 undefined
    mem[8'h42] = pk_wreg(8'h11, 32'd7);                      // 0x210
    mem[8'h43] = pk_addr(4'h1, 4'h0, 16'h128, 32'h0);        // 0x218 return
    mem[8'h60] = 64'hCAFE_0000_0000_0000;                    // 0x300 label
    clear_logs();
    host_wr(1'b0, 16'h100);
    @(negedge clk_i);
    host_we_i = 1'b1; host_sel_i = 1'b1; host_wdata_i = 16'h128;
    @(negedge clk_i);
    host_we_i = 1'b0;
    chk(mem_req_o && !mem_we_o && mem_addr_o == 16'h100 && !idle_o, "R2 first fetch", mem_addr_o, 16'h100);
    run_idle(500, ok);
    chk(ok, "R11 returns idle", ok, 1);
    chk(n_rd == 8, "R11 R12 fetch count", n_rd, 8);
    for (int i = 0; i < 8; i++)
      chk(rd_log[i] == EXP_FETCH[i], "R3 R4 R5 R10 fetch order", rd_log[i], EXP_FETCH[i]);
    chk(n_reg == 3, "R4 R6 reg write count", n_reg, 3);
    chk(reg_log[0] == {8'h5A, 32'hDEAD_BEEF}, "R6 reg write 0", reg_log[0], {8'h5A, 32'hDEAD_BEEF});
    chk(reg_log[1] == {8'h11, 32'd7}, "R6 reg write 1", reg_log[1], {8'h11, 32'd7});
    chk(reg_log[2] == {8'h22, 32'd9}, "R6 reg write 2", reg_log[2], {8'h22, 32'd9});
    chk(n_wr == 1 && wr_log[0] == 16'h300, "R7 label store addr", wr_log[0], 16'h300);
    chk(mem[8'h60] == 64'hCAFE_0000_0000_1234, "R7 label value", mem[8'h60], 64'hCAFE_0000_0000_1234);
    repeat (20) @(negedge clk_i);
    chk(n_rd == 8 && idle_o, "R11 no fetch after last", n_rd, 8);

    summary();
    $finish;
  end
endmodule